// File: doc/BRIEF.md
# Predicated Vector Element Issue Expander

This block sits at the issue stage of a core that runs ordinary scalar operations over runs of registers. It takes one vectorised operation with a destination base register, two source base registers, a vector length and a per-element predicate mask. It hands the work out as single-element scalar operations on N parallel ALU issue slots. Element i works on registers rd+i, rs1+i and rs2+i. Each cycle the lowest-numbered elements still owed, up to N of them, are packed onto slots 0, 1, 2 and so on. Elements whose predicate bit is clear take no slot.

The operation is held inside as a pending set of elements. The set shrinks by the elements each slot accepts, until it is empty. Only then is a new operation taken. A mode bit selects between two behaviours. In skip mode, masked-off elements are simply dropped. In zeroing mode, every element below the vector length is issued, and the masked-off ones are flagged so that the ALU writes zero to their destination. Each slot has its own valid/ready pair. An element offered on a slot that is not ready stays pending and is offered again on the next cycle.

Top module: `vec_issue_expander`

## Requirements
- R1: `in_ready` is 1 exactly when no operation is pending. An operation is taken on a cycle with `in_valid` and `in_ready` both high. Its first elements appear on the slots in the following cycle.
- R2: In skip mode (`in_zero_mode`=0), element i is issued only when bit i of `in_mask` is 1 and i < `in_vl`. A vector length above XLEN behaves as XLEN.
- R3: Each cycle, the pending elements with the lowest indices, up to N of them, are offered on slots 0..k-1 in ascending index order. The offered slots are always a contiguous run starting at slot 0.
- R4: A slot carrying element i shows `slot_idx`=i and register numbers rd+i, rs1+i and rs2+i, each as the low 5 bits of the sum.
- R5: An element leaves the pending set only on a cycle when its slot has valid and ready both high. An element that is offered but not accepted is offered again in the next cycle, re-packed with the others.
- R6: With 8 elements, mask 0xF3 (6 enabled), skip mode and N=4 with all slots ready, 4 elements issue in the first cycle and 2 in the second. With only slot 0 ready, the operation takes 6 issue cycles.
- R7: `done` is high for exactly the cycle in which the last pending element is accepted. At no other time is it high.
- R8: In zeroing mode, every element i < `in_vl` is issued. `slot_zero` is 1 when mask bit i is 0 and 0 when it is 1. In skip mode, `slot_zero` is always 0.
- R9: An operation with nothing to issue (`in_vl`=0, or a mask with no set bit below `in_vl` in skip mode) produces no slot valid and no `done`. `in_ready` stays 1 in the next cycle.
- R10: `err` is 1 in any cycle where a valid slot has rd+i, rs1+i or rs2+i above 31. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New vector operation offered |
| in_ready | output | 1 | No operation pending; new one can be taken |
| in_rd | input | 5 | Destination base register |
| in_rs1 | input | 5 | First source base register |
| in_rs2 | input | 5 | Second source base register |
| in_vl | input | $clog2(XLEN+1) | Vector length |
| in_mask | input | XLEN | Predicate, one bit per element |
| in_zero_mode | input | 1 | 1: zero masked elements, 0: skip them |
| slot_valid | output | N | Per-slot element offered |
| slot_ready | input | N | Per-slot ALU accepts element |
| slot_idx | output | N*$clog2(XLEN) | Element index per slot, slot 0 in low bits |
| slot_rd | output | N*5 | Destination register per slot |
| slot_rs1 | output | N*5 | First source register per slot |
| slot_rs2 | output | N*5 | Second source register per slot |
| slot_zero | output | N | Write zero instead of the result |
| done | output | 1 | Last element of the operation accepted this cycle |
| err | output | 1 | A valid slot computed a register number above 31 |

## Verification
The assertions check, on every cycle, several properties of the slots. The offered slots form a contiguous run with strictly rising element indices. The pending set never gains elements while it drains. `done` comes only with an accepted element and is followed by idle slots. Skip mode never raises a zero flag. Other behaviours can only be shown by the bench's scenarios, which compare against an independent model: which elements issue and with which register numbers, the exact cycle counts for the 1-wide and 4-wide cases, the re-offering of refused elements under random back-pressure, the empty-operation cases, and the overflow flag.

// File: rtl/vie_pkg.sv
package vie_pkg;
    localparam int REGW   = 5;
    localparam int MAXREG = 31;
    typedef logic [REGW-1:0] regnum_t;
endpackage

// File: rtl/vie_pick.sv
module vie_pick #(
    parameter int XLEN = 32,
    parameter int N    = 4,
    localparam int IW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] pend,
    output logic [N-1:0]    found,
    output logic [N*IW-1:0] sel
);
    int cnt;

    always_comb begin
        found = '0;
        sel   = '0;
        cnt   = 0;
        for (int i = 0; i < XLEN; i++) begin
            if (pend[i] && cnt < N) begin
                for (int k = 0; k < N; k++) begin
                    if (cnt == k) begin
                        found[k]          = 1'b1;
                        sel[k*IW +: IW]   = IW'(i);
                    end
                end
                cnt = cnt + 1;
            end
        end
    end

    // R3: offered slots are contiguous from slot 0 with rising indices
    generate
        for (genvar k = 1; k < N; k++) begin : g_chk
            always_comb begin
                if (found[k]) begin
                    p_pack_order_r3: assert (found[k-1] && (sel[k*IW +: IW] > sel[(k-1)*IW +: IW]));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/vie_regcalc.sv
module vie_regcalc
    import vie_pkg::*;
#(
    parameter int IW = 5,
    localparam int SUMW = ((IW > REGW) ? IW : REGW) + 1
) (
    input  regnum_t         base_rd,
    input  regnum_t         base_rs1,
    input  regnum_t         base_rs2,
    input  logic [IW-1:0]   idx,
    output regnum_t         rd,
    output regnum_t         rs1,
    output regnum_t         rs2,
    output logic            ovf
);
    logic [SUMW-1:0] s_rd, s_rs1, s_rs2;

    always_comb begin
        s_rd  = SUMW'(base_rd)  + SUMW'(idx);
        s_rs1 = SUMW'(base_rs1) + SUMW'(idx);
        s_rs2 = SUMW'(base_rs2) + SUMW'(idx);
        rd    = s_rd[REGW-1:0];
        rs1   = s_rs1[REGW-1:0];
        rs2   = s_rs2[REGW-1:0];
        ovf   = (s_rd > SUMW'(MAXREG)) || (s_rs1 > SUMW'(MAXREG)) || (s_rs2 > SUMW'(MAXREG));
    end
endmodule

// File: rtl/vec_issue_expander.sv
module vec_issue_expander
    import vie_pkg::*;
#(
    parameter int N    = 4,
    parameter int XLEN = 32,
    localparam int IW  = $clog2(XLEN),
    localparam int VLW = $clog2(XLEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [REGW-1:0]   in_rd,
    input  logic [REGW-1:0]   in_rs1,
    input  logic [REGW-1:0]   in_rs2,
    input  logic [VLW-1:0]    in_vl,
    input  logic [XLEN-1:0]   in_mask,
    input  logic              in_zero_mode,
    output logic [N-1:0]      slot_valid,
    input  logic [N-1:0]      slot_ready,
    output logic [N*IW-1:0]   slot_idx,
    output logic [N*REGW-1:0] slot_rd,
    output logic [N*REGW-1:0] slot_rs1,
    output logic [N*REGW-1:0] slot_rs2,
    output logic [N-1:0]      slot_zero,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        logic            active;
        logic            zm;
        regnum_t         rd;
        regnum_t         rs1;
        regnum_t         rs2;
        logic [XLEN-1:0] pend;
        logic [XLEN-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]    found;
    logic [N*IW-1:0] sel;
    logic [N-1:0]    ovf;
    logic [N-1:0]    acc;
    logic [XLEN-1:0] gone;
    logic [XLEN-1:0] left;
    logic [XLEN-1:0] vmask;
    logic [XLEN-1:0] pend_new;

    vie_pick #(.XLEN(XLEN), .N(N)) u_pick (
        .pend  (st_q.pend),
        .found (found),
        .sel   (sel)
    );

    generate
        for (genvar k = 0; k < N; k++) begin : g_slot
            vie_regcalc #(.IW(IW)) u_rc (
                .base_rd  (st_q.rd),
                .base_rs1 (st_q.rs1),
                .base_rs2 (st_q.rs2),
                .idx      (sel[k*IW +: IW]),
                .rd       (slot_rd[k*REGW +: REGW]),
                .rs1      (slot_rs1[k*REGW +: REGW]),
                .rs2      (slot_rs2[k*REGW +: REGW]),
                .ovf      (ovf[k])
            );
            assign slot_zero[k] = slot_valid[k] & st_q.zm & ~st_q.mask[sel[k*IW +: IW]];
        end
    endgenerate

    assign slot_valid = found & {N{st_q.active}};
    assign slot_idx   = sel;
    assign acc        = slot_valid & slot_ready;
    assign in_ready   = ~st_q.active;
    assign err        = |(slot_valid & ovf);

    always_comb begin
        gone = '0;
        for (int k = 0; k < N; k++) begin
            if (acc[k]) gone[sel[k*IW +: IW]] = 1'b1;
        end
        left = st_q.pend & ~gone;
        for (int i = 0; i < XLEN; i++) begin
            vmask[i] = (VLW'(i) < in_vl);
        end
        pend_new = in_zero_mode ? vmask : (in_mask & vmask);
        done     = st_q.active & (|acc) & ~(|left);

        st_d = st_q;
        if (!st_q.active) begin
            if (in_valid) begin
                st_d.active = |pend_new;
                st_d.zm     = in_zero_mode;
                st_d.rd     = in_rd;
                st_d.rs1    = in_rs1;
                st_d.rs2    = in_rs2;
                st_d.pend   = pend_new;
                st_d.mask   = in_mask;
            end
        end else begin
            st_d.pend   = left;
            st_d.active = |left;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: pending set never gains elements while draining
    p_pend_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |=> ((st_q.pend & ~$past(st_q.pend)) == '0));

    // R7: done only with an accepted element, and the slots idle afterwards
    p_done_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (|(slot_valid & slot_ready)));
    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (slot_valid == '0));

    // R1: no new operation is taken while one is pending
    p_hold_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !done) |=> !in_ready);

    // R8: skip mode never flags a zero write
    p_skip_no_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.zm |-> (slot_zero == '0));
endmodule

// File: tb/sim_vec_issue_expander.sv
module sim_vec_issue_expander;
    localparam int N    = 4;
    localparam int XLEN = 32;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [4:0]      in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic [5:0]      in_vl = '0;
    logic [31:0]     in_mask = '0;
    logic            in_zero_mode = 1'b0;
    logic [N-1:0]    slot_valid;
    logic [N-1:0]    slot_ready = '0;
    logic [N*IW-1:0] slot_idx;
    logic [N*5-1:0]  slot_rd, slot_rs1, slot_rs2;
    logic [N-1:0]    slot_zero;
    logic            done, err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vec_issue_expander #(.N(N), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_vl(in_vl),
        .in_mask(in_mask), .in_zero_mode(in_zero_mode),
        .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_idx(slot_idx),
        .slot_rd(slot_rd), .slot_rs1(slot_rs1), .slot_rs2(slot_rs2),
        .slot_zero(slot_zero), .done(done), .err(err)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] len_mask(input logic [5:0] vl);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (i < int'(vl));
        return m;
    endfunction

    // expected slot tuple: {valid, idx, rd, rs1, rs2, zero}
    function automatic logic [21:0] tuple(input logic v, input int i, input logic [4:0] rd,
                                          input logic [4:0] rs1, input logic [4:0] rs2, input logic z);
        return {v, 5'(i), 5'(int'(rd) + i), 5'(int'(rs1) + i), 5'(int'(rs2) + i), z};
    endfunction

    // rmode 0: all ready, 1: slot 0 only, 2: random
    task automatic run_op(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                          input logic [5:0] vl, input logic [31:0] mask, input logic zm,
                          input int rmode, output int cycles, output int first_cnt);
        logic [31:0] mp;
        int          eidx [N];
        logic [N-1:0] ev;
        logic        eerr;
        logic        any;
        int          k;
        @(negedge clk);
        check("R1 in_ready before operation", 64'(in_ready), 64'd1);
        in_rd = rd; in_rs1 = rs1; in_rs2 = rs2; in_vl = vl; in_mask = mask;
        in_zero_mode = zm; in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        mp = zm ? len_mask(vl) : (mask & len_mask(vl));
        cycles = 0;
        first_cnt = -1;
        forever begin
            @(negedge clk);
            case (rmode)
                0: slot_ready = '1;
                1: slot_ready = 4'b0001;
                default: slot_ready = N'($urandom) | N'($urandom);
            endcase
            #1;
            check("R1 in_ready while pending", 64'(in_ready), 64'(mp == 0));
            ev = '0; k = 0; eerr = 1'b0;
            for (int i = 0; i < 32; i++) begin
                if (mp[i] && k < N) begin
                    eidx[k] = i; ev[k] = 1'b1;
                    if (int'(rd) + i > 31 || int'(rs1) + i > 31 || int'(rs2) + i > 31) eerr = 1'b1;
                    k++;
                end
            end
            if (first_cnt < 0) first_cnt = k;
            for (int s = 0; s < N; s++) begin
                logic [21:0] act, exp;
                act = {slot_valid[s], slot_idx[s*IW +: IW], slot_rd[s*5 +: 5],
                       slot_rs1[s*5 +: 5], slot_rs2[s*5 +: 5], slot_zero[s]};
                if (ev[s]) exp = tuple(1'b1, eidx[s], rd, rs1, rs2, zm & ~mask[eidx[s]]);
                else       exp = '0;
                if (!ev[s]) act = {slot_valid[s], 21'd0};
                check("R2 R3 R4 R8 slot contents", 64'(act), 64'(exp));
            end
            check("R10 err flag", 64'(err), 64'(eerr));
            any = 1'b0;
            for (int s = 0; s < N; s++) begin
                if (ev[s] && slot_ready[s]) begin mp[eidx[s]] = 1'b0; any = 1'b1; end
            end
            check("R7 R9 done pulse", 64'(done), 64'(any && mp == 0));
            if (ev != 0) cycles++;
            if (mp == 0) break;
        end
    endtask

    initial begin
        int cyc, fc;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset in_ready", 64'(in_ready), 64'd1);
        check("R7 reset outputs", 64'({slot_valid, done, err}), 64'd0);
        rst_n = 1'b1;

        run_op(5'd1, 5'd8, 5'd16, 6'd8, 32'h0000_00F3, 1'b0, 0, cyc, fc);
        check("R6 4-wide issue cycles", 64'(cyc), 64'd2);
        check("R6 4-wide first-cycle count", 64'(fc), 64'd4);
        run_op(5'd1, 5'd8, 5'd16, 6'd8, 32'h0000_00F3, 1'b0, 1, cyc, fc);
        check("R6 1-wide issue cycles", 64'(cyc), 64'd6);

        run_op(5'd0, 5'd0, 5'd0, 6'd0, 32'hFFFF_FFFF, 1'b0, 0, cyc, fc);
        check("R9 vl zero issues nothing", 64'(cyc), 64'd0);
        run_op(5'd3, 5'd4, 5'd5, 6'd16, 32'hFFFF_0000, 1'b0, 0, cyc, fc);
        check("R9 no enabled bit below vl", 64'(cyc), 64'd0);
        run_op(5'd0, 5'd0, 5'd0, 6'd0, 32'h0, 1'b1, 0, cyc, fc);
        check("R9 zero mode with vl zero", 64'(cyc), 64'd0);

        run_op(5'd10, 5'd2, 5'd20, 6'd5, 32'h0, 1'b1, 0, cyc, fc);
        check("R8 zero mode all masked", 64'(cyc), 64'd2);
        run_op(5'd0, 5'd0, 5'd0, 6'd40, 32'hFFFF_FFFF, 1'b0, 0, cyc, fc);
        check("R2 vl above XLEN clamps", 64'(cyc), 64'd8);
        run_op(5'd30, 5'd0, 5'd0, 6'd4, 32'h0000_000F, 1'b0, 0, cyc, fc);
        run_op(5'd0, 5'd0, 5'd0, 6'd32, 32'h8000_0001, 1'b0, 2, cyc, fc);

        for (int t = 0; t < 150; t++) begin
            logic [31:0] m;
            m = ($urandom % 2 == 0) ? ($urandom & $urandom) : $urandom;
            run_op(5'($urandom % 32), 5'($urandom % 32), 5'($urandom % 32),
                   6'($urandom % 40), m, ($urandom % 4) == 0, 2, cyc, fc);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule